// File: doc/BRIEF.md
# Serial Controller Register Bank

This block is the register file of a small serial controller. It sits on a simple register bus that carries a byte offset, write and read strobes, and write data. It holds the controller's configuration: framing mode, bit-rate divisor, control word, FIFO control and port bits. It also keeps five status flags that software clears by writing zeros. A write to the transmit data register hands the byte straight to the transmitter through a byte output with a one-cycle valid strobe.

An elaboration parameter picks between two variants. The basic variant has only the four core registers. The FIFO variant adds the status, FIFO control, receive count, port and line status registers, and it masks a few reserved bits in the mode and control words. The block flags every access to an offset that is not implemented in the selected variant. Read data is registered and comes back on the cycle after the read strobe.

Top module: `sercfg_regs`

## Requirements
- R1: After reset the mode register reads 0x00, the bit-rate register 0xFF, the control register 0x20, FIFO control 0x0000, port 0x00 and receive count 0x00. The status register reads 0x60, meaning transmit-end and transmit-empty are set. The transmit data register reads 0xFF in the basic variant and 0x00 in the FIFO variant.
- R2: A read strobe gives `bus_rvalid` high for exactly the next cycle, with `bus_rdata` holding the addressed register, 8-bit registers zero-extended to 16 bits. Mode is at offset 0x00, bit rate at 0x04, control at 0x08 and transmit data at 0x0C.
- R3: A write to the mode register (0x00) stores the write data ANDed with 0x7B in the FIFO variant, and all 8 low bits in the basic variant.
- R4: A write to the control register (0x08) stores the data ANDed with 0xFB in the FIFO variant and all 8 bits in the basic variant. Bit 5 is transmit enable. A control write with bit 5 equal to 0 sets the transmit-end flag.
- R5: A write to transmit data (0x0C) stores the low byte and puts it on `tx_byte`, with `tx_valid` high for exactly the following cycle. It also clears transmit-empty. `tx_valid` is low after every other kind of access.
- R6: Status (0x10, FIFO variant) uses bit 6 for transmit-end, bit 5 for transmit-empty, bit 4 for break, bit 1 for receive-full and bit 0 for data-ready. A status write clears each flag whose bit is 0 and leaves a flag alone when its bit is 1.
- R7: A status read returns the flags as they were before the read. If control bit 5 is 1 at the time of the read, transmit-empty and transmit-end are both set afterwards. If bit 5 is 0, the flags are left as they were.
- R8: Line status (0x24) accepts writes and ignores them, and reads as 0. Receive count (0x1C) reads as 0.
- R9: FIFO control (0x18) keeps all 16 written bits, and port (0x20) keeps the low 8 bits. Both read back.
- R10: An access that is unaligned, at or above 0x28, at 0x14, or a write to 0x1C is unsupported. Such an access makes `acc_err` high for exactly the next cycle, makes an unsupported read return 0, and changes no register. A supported access leaves `acc_err` low.
- R11: In the basic variant, every access to 0x10, 0x18, 0x1C, 0x20 and 0x24 is unsupported and is treated as in R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, one cycle after the read strobe |
| bus_rvalid | output | 1 | Read data valid |
| tx_byte | output | 8 | Byte handed to the transmitter |
| tx_valid | output | 1 | One-cycle strobe for tx_byte |
| acc_err | output | 1 | One-cycle pulse for an unsupported access |

## Verification
The bench runs the FIFO and basic variants side by side on the same bus and targets the status flag rules. A design that clears a flag on a written one, or that misses the re-arm on a status read with transmit enabled, fails the read after the clear. It also fails if it returns the flags after the re-arm instead of before it. The bench checks that the mask constants apply only in the FIFO variant, so a design that masks in the basic variant reads back the wrong mode or control value. Unaligned, out-of-window and variant-only offsets are sent to both variants, so an error pulse that is missing or lasts too long is caught. The same stimulus catches a register that an unsupported write altered, and that change shows up on a later read.

// File: rtl/serport_pkg.sv
package serport_pkg;

    localparam logic [7:0] OFF_MODE = 8'h00;
    localparam logic [7:0] OFF_BRR  = 8'h04;
    localparam logic [7:0] OFF_CTRL = 8'h08;
    localparam logic [7:0] OFF_DATA = 8'h0C;
    localparam logic [7:0] OFF_STAT = 8'h10;
    localparam logic [7:0] OFF_FCR  = 8'h18;
    localparam logic [7:0] OFF_RXC  = 8'h1C;
    localparam logic [7:0] OFF_PORT = 8'h20;
    localparam logic [7:0] OFF_LINE = 8'h24;
    localparam int unsigned WINDOW  = 32'h28;

    localparam logic [7:0] MODE_MASK_FIFO = 8'h7B;
    localparam logic [7:0] CTRL_MASK_FIFO = 8'hFB;
    localparam int TXEN_BIT = 5;

    typedef enum logic [3:0] {
        REG_MODE, REG_BRR, REG_CTRL, REG_DATA, REG_STAT,
        REG_FCR, REG_RXC, REG_PORT, REG_LINE, REG_NONE
    } reg_t;

    typedef struct packed {
        logic tend;
        logic tde;
        logic brk;
        logic rdf;
        logic dr;
    } flags_t;

    localparam flags_t FLAGS_RST = '{tend: 1'b1, tde: 1'b1, brk: 1'b0, rdf: 1'b0, dr: 1'b0};

    function automatic reg_t decode_off(input logic [31:0] off);
        if (off[1:0] != 2'b00 || off >= WINDOW) return REG_NONE;
        case (off[7:0])
            OFF_MODE: return REG_MODE;
            OFF_BRR:  return REG_BRR;
            OFF_CTRL: return REG_CTRL;
            OFF_DATA: return REG_DATA;
            OFF_STAT: return REG_STAT;
            OFF_FCR:  return REG_FCR;
            OFF_RXC:  return REG_RXC;
            OFF_PORT: return REG_PORT;
            OFF_LINE: return REG_LINE;
            default:  return REG_NONE;
        endcase
    endfunction

    function automatic logic can_write(input reg_t r, input logic fifo);
        case (r)
            REG_MODE, REG_BRR, REG_CTRL, REG_DATA: return 1'b1;
            REG_STAT, REG_FCR, REG_PORT, REG_LINE: return fifo;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic can_read(input reg_t r, input logic fifo);
        case (r)
            REG_MODE, REG_BRR, REG_CTRL, REG_DATA: return 1'b1;
            REG_STAT, REG_FCR, REG_RXC, REG_PORT, REG_LINE: return fifo;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [7:0] pack_status(input flags_t f);
        return {1'b0, f.tend, f.tde, f.brk, 2'b00, f.rdf, f.dr};
    endfunction

endpackage

// File: rtl/sercfg_decode.sv
module sercfg_decode
    import serport_pkg::*;
#(
    parameter bit FIFO_MODE = 1'b1,
    parameter int ADDR_W    = 6
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output reg_t              sel,
    output logic              wr_hit,
    output logic              rd_hit,
    output logic              bad
);
    always_comb begin
        sel    = decode_off(32'(addr));
        wr_hit = wr && can_write(sel, FIFO_MODE);
        rd_hit = rd && can_read(sel, FIFO_MODE);
        bad    = (wr && !wr_hit) || (rd && !rd_hit);
    end
endmodule

// File: rtl/sercfg_cfg.sv
module sercfg_cfg
    import serport_pkg::*;
#(
    parameter bit FIFO_MODE = 1'b1,
    parameter int DATA_W    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  reg_t              sel,
    input  logic              wr_hit,
    input  logic [DATA_W-1:0] wdata,
    output logic [7:0]        mode_q,
    output logic [7:0]        brr_q,
    output logic [7:0]        ctrl_q,
    output logic [7:0]        data_q,
    output logic [DATA_W-1:0] fcr_q,
    output logic [7:0]        port_q,
    output logic              tx_valid
);
    logic [7:0] mode_mask;
    logic [7:0] ctrl_mask;
    logic [7:0] data_rst;

    generate
        if (FIFO_MODE) begin : g_fifo
            assign mode_mask = MODE_MASK_FIFO;
            assign ctrl_mask = CTRL_MASK_FIFO;
            assign data_rst  = 8'h00;
        end else begin : g_basic
            assign mode_mask = 8'hFF;
            assign ctrl_mask = 8'hFF;
            assign data_rst  = 8'hFF;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= 8'h00;
            brr_q    <= 8'hFF;
            ctrl_q   <= 8'h20;
            data_q   <= data_rst;
            fcr_q    <= '0;
            port_q   <= 8'h00;
            tx_valid <= 1'b0;
        end else begin
            tx_valid <= 1'b0;
            if (wr_hit) begin
                case (sel)
                    REG_MODE: mode_q <= wdata[7:0] & mode_mask;
                    REG_BRR:  brr_q  <= wdata[7:0];
                    REG_CTRL: ctrl_q <= wdata[7:0] & ctrl_mask;
                    REG_DATA: begin
                        data_q   <= wdata[7:0];
                        tx_valid <= 1'b1;
                    end
                    REG_FCR:  fcr_q  <= wdata;
                    REG_PORT: port_q <= wdata[7:0];
                    default:  ;
                endcase
            end
        end
    end

    AST_TX_STROBE: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && sel == REG_DATA) |=> (tx_valid && data_q == $past(wdata[7:0]))); // R5
    AST_TX_QUIET: assert property (@(posedge clk) disable iff (rst)
        !(wr_hit && sel == REG_DATA) |=> !tx_valid); // R5

    generate
        if (FIFO_MODE) begin : g_mask_chk
            AST_MODE_MASK: assert property (@(posedge clk) disable iff (rst)
                (wr_hit && sel == REG_MODE) |=> ((mode_q & ~MODE_MASK_FIFO) == 8'h00)); // R3
        end
    endgenerate
endmodule

// File: rtl/sercfg_flags.sv
module sercfg_flags
    import serport_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  reg_t       sel,
    input  logic       wr_hit,
    input  logic       rd_hit,
    input  logic [7:0] wbyte,
    input  logic       txen,
    output flags_t     fl
);
    logic   stat_wr, stat_rd, data_wr, ctrl_wr;
    flags_t nxt;

    always_comb begin
        stat_wr = wr_hit && sel == REG_STAT;
        stat_rd = rd_hit && sel == REG_STAT;
        data_wr = wr_hit && sel == REG_DATA;
        ctrl_wr = wr_hit && sel == REG_CTRL;
        nxt = fl;
        if (stat_wr) begin
            if (!wbyte[6]) nxt.tend = 1'b0;
            if (!wbyte[5]) nxt.tde  = 1'b0;
            if (!wbyte[4]) nxt.brk  = 1'b0;
            if (!wbyte[1]) nxt.rdf  = 1'b0;
            if (!wbyte[0]) nxt.dr   = 1'b0;
        end
        if (data_wr) nxt.tde = 1'b0;
        if (ctrl_wr && !wbyte[TXEN_BIT]) nxt.tend = 1'b1;
        if (stat_rd && txen) begin
            nxt.tde  = 1'b1;
            nxt.tend = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) fl <= FLAGS_RST;
        else     fl <= nxt;
    end

    AST_TDE_DROP: assert property (@(posedge clk) disable iff (rst)
        (data_wr && !stat_rd) |=> !fl.tde); // R5
    AST_TEND_SET: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && !wbyte[TXEN_BIT]) |=> fl.tend); // R4
    AST_REARM: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && txen) |=> (fl.tde && fl.tend)); // R7
    AST_W0_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (stat_wr && !wbyte[6] && !stat_rd) |=> !fl.tend); // R6
    AST_W1_KEEP: assert property (@(posedge clk) disable iff (rst)
        (stat_wr && wbyte[6] && fl.tend) |=> fl.tend); // R6
endmodule

// File: rtl/sercfg_regs.sv
module sercfg_regs
    import serport_pkg::*;
#(
    parameter bit FIFO_MODE = 1'b1,
    parameter int ADDR_W    = 6,
    parameter int DATA_W    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    output logic [7:0]        tx_byte,
    output logic              tx_valid,
    output logic              acc_err
);
    localparam int PAD = DATA_W - 8;

    reg_t              sel;
    logic              wr_hit, rd_hit, bad;
    logic [7:0]        mode_q, brr_q, ctrl_q, data_q, port_q;
    logic [DATA_W-1:0] fcr_q;
    flags_t            fl;
    logic [DATA_W-1:0] rd_val;

    sercfg_decode #(.FIFO_MODE(FIFO_MODE), .ADDR_W(ADDR_W)) u_dec (
        .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
        .sel(sel), .wr_hit(wr_hit), .rd_hit(rd_hit), .bad(bad)
    );

    sercfg_cfg #(.FIFO_MODE(FIFO_MODE), .DATA_W(DATA_W)) u_cfg (
        .clk(clk), .rst(rst), .sel(sel), .wr_hit(wr_hit), .wdata(bus_wdata),
        .mode_q(mode_q), .brr_q(brr_q), .ctrl_q(ctrl_q), .data_q(data_q),
        .fcr_q(fcr_q), .port_q(port_q), .tx_valid(tx_valid)
    );

    sercfg_flags u_flg (
        .clk(clk), .rst(rst), .sel(sel), .wr_hit(wr_hit), .rd_hit(rd_hit),
        .wbyte(bus_wdata[7:0]), .txen(ctrl_q[TXEN_BIT]), .fl(fl)
    );

    assign tx_byte = data_q;

    always_comb begin
        case (sel)
            REG_MODE: rd_val = {{PAD{1'b0}}, mode_q};
            REG_BRR:  rd_val = {{PAD{1'b0}}, brr_q};
            REG_CTRL: rd_val = {{PAD{1'b0}}, ctrl_q};
            REG_DATA: rd_val = {{PAD{1'b0}}, data_q};
            REG_STAT: rd_val = {{PAD{1'b0}}, pack_status(fl)};
            REG_FCR:  rd_val = fcr_q;
            REG_PORT: rd_val = {{PAD{1'b0}}, port_q};
            default:  rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
            acc_err    <= 1'b0;
        end else begin
            bus_rdata  <= rd_hit ? rd_val : '0;
            bus_rvalid <= bus_rd;
            acc_err    <= bad;
        end
    end

    AST_RVALID: assert property (@(posedge clk) disable iff (rst)
        bus_rd |=> bus_rvalid); // R2
    AST_BAD_RDATA: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !rd_hit) |=> (bus_rdata == '0)); // R10
    AST_OUT_WINDOW: assert property (@(posedge clk) disable iff (rst)
        ((bus_wr || bus_rd) && 32'(bus_addr) >= WINDOW) |=> acc_err); // R10
    AST_LINE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && (sel == REG_LINE || sel == REG_RXC)) |=> (bus_rdata == '0)); // R8

    generate
        if (!FIFO_MODE) begin : g_basic_chk
            AST_NO_STATUS: assert property (@(posedge clk) disable iff (rst)
                (bus_rd && 32'(bus_addr) == 32'(OFF_STAT)) |=> acc_err); // R11
        end
    endgenerate
endmodule

// File: tb/tb_sercfg_regs.sv
`timescale 1ns/1ps
module tb_sercfg_regs;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] rdata_o [2];
    logic        rvalid_o [2];
    logic [7:0]  txb_o [2];
    logic        txv_o [2];
    logic        err_o [2];

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;
    string tag_ovr = "";

    always #10 clk = ~clk;

    sercfg_regs #(.FIFO_MODE(1'b1)) dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_o[1]), .bus_rvalid(rvalid_o[1]),
        .tx_byte(txb_o[1]), .tx_valid(txv_o[1]), .acc_err(err_o[1])
    );
    sercfg_regs #(.FIFO_MODE(1'b0)) dut_sci (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_o[0]), .bus_rvalid(rvalid_o[0]),
        .tx_byte(txb_o[0]), .tx_valid(txv_o[0]), .acc_err(err_o[0])
    );

    // expected-state model, index 1 = FIFO variant, 0 = basic
    logic [7:0]  m_mode [2], m_brr [2], m_ctrl [2], m_data [2], m_port [2];
    logic [15:0] m_fcr [2];
    logic        m_tend [2], m_tde [2];

    function automatic bit f_aligned(int a);
        return (a % 4 == 0) && a < 'h28 && a != 'h14;
    endfunction
    function automatic bit f_wr_ok(int m, int a);
        if (!f_aligned(a)) return 0;
        if (a <= 'h0C) return 1;
        return (m == 1) && (a == 'h10 || a == 'h18 || a == 'h20 || a == 'h24);
    endfunction
    function automatic bit f_rd_ok(int m, int a);
        if (!f_aligned(a)) return 0;
        if (a <= 'h0C) return 1;
        return m == 1;
    endfunction
    function automatic logic [15:0] f_read(int m, int a);
        if (!f_rd_ok(m, a)) return 16'h0;
        case (a)
            'h00: return {8'h0, m_mode[m]};
            'h04: return {8'h0, m_brr[m]};
            'h08: return {8'h0, m_ctrl[m]};
            'h0C: return {8'h0, m_data[m]};
            'h10: return {9'h0, m_tend[m], m_tde[m], 5'h0};
            'h18: return m_fcr[m];
            'h20: return {8'h0, m_port[m]};
            default: return 16'h0;
        endcase
    endfunction
    function automatic string f_tag(int m, int a);
        if (tag_ovr != "") return tag_ovr;
        if (!f_rd_ok(m, a)) return (m == 1) ? "R10" : "R11";
        case (a)
            'h00: return "R3";
            'h04: return "R2";
            'h08: return "R4";
            'h0C: return "R5";
            'h10: return "R7";
            'h18, 'h20: return "R9";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int m = 0; m < 2; m++) begin
            m_mode[m] = 8'h00; m_brr[m] = 8'hFF; m_ctrl[m] = 8'h20;
            m_data[m] = (m == 1) ? 8'h00 : 8'hFF; m_port[m] = 8'h00;
            m_fcr[m] = 16'h0; m_tend[m] = 1'b1; m_tde[m] = 1'b1;
        end
    endtask

    task automatic access(bit w, bit r, int a, logic [15:0] d);
        logic [15:0] e_rd [2];
        bit e_err [2];
        bit e_tx [2];
        @(negedge clk);
        bus_addr = 6'(a); bus_wr = w; bus_rd = r; bus_wdata = d;
        for (int m = 0; m < 2; m++) begin
            e_rd[m]  = f_read(m, a);
            e_err[m] = (w && !f_wr_ok(m, a)) || (r && !f_rd_ok(m, a));
            e_tx[m]  = w && f_wr_ok(m, a) && a == 'h0C;
            if (w && f_wr_ok(m, a)) begin
                case (a)
                    'h00: m_mode[m] = d[7:0] & ((m == 1) ? 8'h7B : 8'hFF);
                    'h04: m_brr[m] = d[7:0];
                    'h08: begin
                        m_ctrl[m] = d[7:0] & ((m == 1) ? 8'hFB : 8'hFF);
                        if (!d[5]) m_tend[m] = 1'b1;
                    end
                    'h0C: begin m_data[m] = d[7:0]; m_tde[m] = 1'b0; end
                    'h10: begin
                        if (!d[6]) m_tend[m] = 1'b0;
                        if (!d[5]) m_tde[m] = 1'b0;
                    end
                    'h18: m_fcr[m] = d;
                    'h20: m_port[m] = d[7:0];
                    default: ;
                endcase
            end
            if (r && f_rd_ok(m, a) && a == 'h10 && m_ctrl[m][5]) begin
                m_tend[m] = 1'b1; m_tde[m] = 1'b1;
            end
        end
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        for (int m = 0; m < 2; m++) begin
            chk("R2", 32'(rvalid_o[m]), 32'(r));
            if (r) chk(f_tag(m, a), 32'(rdata_o[m]), 32'(e_rd[m]));
            chk((m == 1) ? "R10" : "R11", 32'(err_o[m]), 32'(e_err[m]));
            chk("R5", 32'(txv_o[m]), 32'(e_tx[m]));
            if (e_tx[m]) chk("R5", 32'(txb_o[m]), 32'(d[7:0]));
        end
    endtask

    task automatic rd(int a);            access(1'b0, 1'b1, a, 16'h0); endtask
    task automatic wr(int a, logic [15:0] d); access(1'b1, 1'b0, a, d); endtask

    initial begin
        int seed;
        seed = $urandom(32'd2024);
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset values in both variants
        tag_ovr = "R1";
        foreach (OFFS[i]) rd(OFFS[i]);
        tag_ovr = "";
        // R3 / R4 masking and tend set
        wr('h00, 16'h00FF); rd('h00);
        wr('h08, 16'h00FF); rd('h08);
        wr('h08, 16'h0000); rd('h10);
        // R5 data write, tde clear
        wr('h0C, 16'h12A5); rd('h0C); rd('h10); rd('h10);
        // R7 re-arm with transmit enabled
        wr('h08, 16'h0020); rd('h10); rd('h10);
        // R6 zero clears, one keeps
        tag_ovr = "R6";
        wr('h10, 16'h0020); rd('h10);
        wr('h08, 16'h0000); wr('h10, 16'h00FF); rd('h10);
        wr('h10, 16'h0000); rd('h10); rd('h10);
        tag_ovr = "";
        // R8 / R9
        wr('h24, 16'hFFFF); rd('h24); rd('h1C);
        wr('h18, 16'hBEEF); rd('h18);
        wr('h20, 16'h015A); rd('h20);
        // R10 / R11 unsupported accesses
        wr('h14, 16'h00FF); rd('h14);
        wr('h02, 16'h0011); rd('h01);
        wr('h28, 16'h0022); rd('h3C);
        wr('h1C, 16'h0033); rd('h00); rd('h04);
        // random mix
        for (int i = 0; i < 400; i++) begin
            int a;
            a = int'($urandom_range(0, 15)) * 4;
            if ($urandom_range(0, 9) == 0) a = a + 1;
            if ($urandom_range(0, 1) == 1) wr(a, 16'($urandom));
            else rd(a);
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    localparam int OFFS [9] = '{'h00, 'h04, 'h08, 'h0C, 'h10, 'h18, 'h1C, 'h20, 'h24};

    initial begin
        #(20 * 50000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule